// File: doc/BRIEF.md
# Five-Channel Register-Mapped PWM Controller

This block generates five independent pulse-width modulated outputs from a single clock. Software programs it over a simple word-wide register bus. Writes are strobed with `bus_wr` and reads are combinational from `bus_addr`. One shared word holds a run bit per channel. Each channel owns an address window, and the windows sit at a fixed stride. A window holds a control word, a period value and a duty threshold. The control word carries a 3-bit field that divides the input clock by a power of two, from 1 to 128. The window also holds four spare 16-bit words that read back as written and change nothing.

Each channel is a two-state machine. In CH_OFF the output is low, and the counter and prescaler are held at zero. The channel also keeps copying its live register values into a set of shadow copies. The transition enable-set moves CH_OFF to CH_RUN. In CH_RUN the prescaled counter steps from 0 to period-1 and wraps. The output is high while the counter is below the shadowed threshold. At each wrap the shadows reload, so reprogramming never cuts a period short or stretches it. The transition enable-clear moves CH_RUN back to CH_OFF.

Top module: `pwmc_top`

## Requirements
- R1: After reset every output is low and every register reads zero.
- R2: The word at byte address 0x00 holds the run bits, with bit n for channel n (n = 0..4). Its bits 31:5 read zero. Channels change state only through their own bit, so a read-modify-write of one bit leaves the other channels running undisturbed.
- R3: Channel n's window starts at byte address 0x10 + n*0x40. Inside the window, the control word is at +0x00, the period at +0x2C and the threshold at +0x30. Each window's registers are separate storage.
- R4: Control bits 2:0 give k. While the channel runs, its counter advances once every 2^k input clocks, so the high time is threshold*2^k clocks and the period is period*2^k clocks.
- R5: With k = 0, a running channel repeats a period of `period` clocks. The output is high for the first `threshold` of those clocks and low for the rest.
- R6: A threshold of 0 gives a constant low output. A threshold equal to or above the period gives a constant high output.
- R7: While its run bit is clear, a channel holds its output low. Once the run bit is written to 1, the output is low in the first cycle after the write edge. A fresh period begins on the following cycle, with the output high when the threshold is 1 or more.
- R8: Period, threshold and divider writes made during a period take effect only at the next period boundary. The period in progress finishes with the old values.
- R9: The control word and the spare words at window offsets +0x04, +0x08, +0x0C and +0x28 store bits 15:0 and read them back exactly. Their bits 31:16 read zero. The spare words have no effect on the output.
- R10: The period and threshold are 13 bits wide. Writing 0xFFFF reads back 0x1FFF. A period of 8191 runs at full length.
- R11: Reads of any other byte address, including addresses that are not word-aligned, return zero. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 9 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 5 | One PWM output per channel |

## Verification
The output waveform is measured rising edge to rising edge, which gives the high length and the period length. This is done with several period and threshold pairs at divide-by-1, and again at divide-by-4 and divide-by-128, so a wrong tick rate shows up as a scaled length. The first cycles after a run bit is set are sampled one by one, which catches an extra or a missing start cycle. Thresholds of 0, of exactly the period and of the 13-bit maximum separate the compare edge cases. A write made in the middle of a period distinguishes shadowed loading from immediate loading. Readbacks across all five windows, plus writes to holes and misaligned addresses, expose decode aliasing.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int NUM_CH     = 5;
    localparam int CNT_W      = 13;
    localparam int DIV_W      = 3;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 9;
    localparam int AUX_W      = 16;
    localparam int WIN_BASE   = 16;
    localparam int WIN_STRIDE = 64;

    // byte offsets inside one channel window
    localparam int OFS_CTRL   = 0;
    localparam int OFS_SPARE0 = 4;
    localparam int OFS_SPARE1 = 8;
    localparam int OFS_SPARE2 = 12;
    localparam int OFS_SPARE3 = 40;
    localparam int OFS_PERIOD = 44;
    localparam int OFS_THRESH = 48;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_t;

endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs #(
    parameter int NUM_CH     = pwmc_pkg::NUM_CH,
    parameter int CNT_W      = pwmc_pkg::CNT_W,
    parameter int DIV_W      = pwmc_pkg::DIV_W,
    parameter int ADDR_W     = pwmc_pkg::ADDR_W,
    parameter int DATA_W     = pwmc_pkg::DATA_W,
    parameter int AUX_W      = pwmc_pkg::AUX_W,
    parameter int WIN_BASE   = pwmc_pkg::WIN_BASE,
    parameter int WIN_STRIDE = pwmc_pkg::WIN_STRIDE
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic [NUM_CH-1:0]                en_bits,
    output logic [NUM_CH-1:0][DIV_W-1:0]     div_sel,
    output logic [NUM_CH-1:0][CNT_W-1:0]     per_val,
    output logic [NUM_CH-1:0][CNT_W-1:0]     thr_val
);
    import pwmc_pkg::*;

    logic                          s_en;
    logic [NUM_CH-1:0]             s_ctrl, s_sp0, s_sp1, s_sp2, s_sp3, s_per, s_thr;

    logic [NUM_CH-1:0]             en_q;
    logic [NUM_CH-1:0][AUX_W-1:0]  ctrl_q, sp0_q, sp1_q, sp2_q, sp3_q;
    logic [NUM_CH-1:0][CNT_W-1:0]  per_q, thr_q;

    logic                          unused_wdata;
    assign unused_wdata = ^bus_wdata[DATA_W-1:AUX_W];

    assign s_en = (bus_addr == '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE + i * WIN_STRIDE);
        assign s_ctrl[i] = (bus_addr == BASE + ADDR_W'(OFS_CTRL));
        assign s_sp0[i]  = (bus_addr == BASE + ADDR_W'(OFS_SPARE0));
        assign s_sp1[i]  = (bus_addr == BASE + ADDR_W'(OFS_SPARE1));
        assign s_sp2[i]  = (bus_addr == BASE + ADDR_W'(OFS_SPARE2));
        assign s_sp3[i]  = (bus_addr == BASE + ADDR_W'(OFS_SPARE3));
        assign s_per[i]  = (bus_addr == BASE + ADDR_W'(OFS_PERIOD));
        assign s_thr[i]  = (bus_addr == BASE + ADDR_W'(OFS_THRESH));

        assign div_sel[i] = ctrl_q[i][DIV_W-1:0];
        assign per_val[i] = per_q[i];
        assign thr_val[i] = thr_q[i];
    end

    assign en_bits = en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            ctrl_q <= '0;
            sp0_q  <= '0;
            sp1_q  <= '0;
            sp2_q  <= '0;
            sp3_q  <= '0;
            per_q  <= '0;
            thr_q  <= '0;
        end else if (bus_wr) begin
            if (s_en) begin
                en_q <= bus_wdata[NUM_CH-1:0];
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (s_ctrl[i]) ctrl_q[i] <= bus_wdata[AUX_W-1:0];
                if (s_sp0[i])  sp0_q[i]  <= bus_wdata[AUX_W-1:0];
                if (s_sp1[i])  sp1_q[i]  <= bus_wdata[AUX_W-1:0];
                if (s_sp2[i])  sp2_q[i]  <= bus_wdata[AUX_W-1:0];
                if (s_sp3[i])  sp3_q[i]  <= bus_wdata[AUX_W-1:0];
                if (s_per[i])  per_q[i]  <= bus_wdata[CNT_W-1:0];
                if (s_thr[i])  thr_q[i]  <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (s_en) begin
            bus_rdata = DATA_W'(en_q);
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (s_ctrl[i]) bus_rdata = DATA_W'(ctrl_q[i]);
            if (s_sp0[i])  bus_rdata = DATA_W'(sp0_q[i]);
            if (s_sp1[i])  bus_rdata = DATA_W'(sp1_q[i]);
            if (s_sp2[i])  bus_rdata = DATA_W'(sp2_q[i]);
            if (s_sp3[i])  bus_rdata = DATA_W'(sp3_q[i]);
            if (s_per[i])  bus_rdata = DATA_W'(per_q[i]);
            if (s_thr[i])  bus_rdata = DATA_W'(thr_q[i]);
        end
    end

endmodule

// File: rtl/pwmc_prescale.sv
module pwmc_prescale #(
    parameter int DIV_W = pwmc_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // terminal count 2^div - 1, built as a thermometer of div ones
    always_comb begin
        mask = '0;
        for (int b = 0; b < PRE_W; b++) begin
            mask[b] = (b < int'(div));
        end
    end

    assign tick = (pre_q == mask) && !clear;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel #(
    parameter int CNT_W = pwmc_pkg::CNT_W,
    parameter int DIV_W = pwmc_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_in,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] thr_in,
    output logic             pwm_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_sh_o,
    output logic [CNT_W-1:0] thr_sh_o
);
    import pwmc_pkg::*;

    ch_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, per_q, thr_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W:0]   cnt_inc;
    logic             tick, wrap, running;

    assign running = (state_q == CH_RUN);
    assign cnt_inc = {1'b0, cnt_q} + (CNT_W + 1)'(1);
    assign wrap    = (cnt_inc >= {1'b0, per_q});

    pwmc_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!running),
        .div   (div_q),
        .tick  (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: enable-set and enable-clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: if (enable)  state_d = CH_RUN;
            CH_RUN: if (!enable) state_d = CH_OFF;
        endcase
    end

    // counter and shadow copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= '0;
            thr_q <= '0;
            div_q <= '0;
        end else if (!running) begin
            cnt_q <= '0;
            per_q <= per_in;
            thr_q <= thr_in;
            div_q <= div_in;
        end else if (tick) begin
            if (wrap) begin
                cnt_q <= '0;
                per_q <= per_in;
                thr_q <= thr_in;
                div_q <= div_in;
            end else begin
                cnt_q <= cnt_inc[CNT_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        pwm_o    = running && (cnt_q < thr_q);
        cnt_o    = cnt_q;
        per_sh_o = per_q;
        thr_sh_o = thr_q;
    end

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top #(
    parameter int NUM_CH     = pwmc_pkg::NUM_CH,
    parameter int CNT_W      = pwmc_pkg::CNT_W,
    parameter int DIV_W      = pwmc_pkg::DIV_W,
    parameter int ADDR_W     = pwmc_pkg::ADDR_W,
    parameter int DATA_W     = pwmc_pkg::DATA_W,
    parameter int AUX_W      = pwmc_pkg::AUX_W,
    parameter int WIN_BASE   = pwmc_pkg::WIN_BASE,
    parameter int WIN_STRIDE = pwmc_pkg::WIN_STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0]            en_bits;
    logic [NUM_CH-1:0][DIV_W-1:0] div_sel;
    logic [NUM_CH-1:0][CNT_W-1:0] per_val, thr_val;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_all, per_sh_all, thr_sh_all;

    pwmc_regs #(
        .NUM_CH     (NUM_CH),
        .CNT_W      (CNT_W),
        .DIV_W      (DIV_W),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .AUX_W      (AUX_W),
        .WIN_BASE   (WIN_BASE),
        .WIN_STRIDE (WIN_STRIDE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_bits   (en_bits),
        .div_sel   (div_sel),
        .per_val   (per_val),
        .thr_val   (thr_val)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwmc_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (en_bits[i]),
            .div_in   (div_sel[i]),
            .per_in   (per_val[i]),
            .thr_in   (thr_val[i]),
            .pwm_o    (pwm_out[i]),
            .cnt_o    (cnt_all[i]),
            .per_sh_o (per_sh_all[i]),
            .thr_sh_o (thr_sh_all[i])
        );
    end

endmodule

// File: rtl/pwmc_chk.sv
module pwmc_chk #(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 13,
    parameter int ADDR_W = 9
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_wr,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [NUM_CH-1:0]            wdata_lo,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic [NUM_CH-1:0]            en_bits,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
    input logic [NUM_CH-1:0][CNT_W-1:0] per_sh_all,
    input logic [NUM_CH-1:0][CNT_W-1:0] thr_sh_all
);

    assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0) |=> (en_bits == $past(wdata_lo)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
        assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !en_bits[i] |=> !pwm_out[i]);

        assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_all[i] == '0) || (cnt_all[i] < per_sh_all[i]));

        assert_thr_zero_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_sh_all[i] == '0) |-> !pwm_out[i]);

        assert_full_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (en_bits[i] && $past(en_bits[i]) && per_sh_all[i] != '0 &&
             thr_sh_all[i] >= per_sh_all[i]) |-> pwm_out[i]);

        assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(thr_sh_all[i]) || !$stable(per_sh_all[i])) |-> (cnt_all[i] == '0));
    end

endmodule

bind pwmc_top pwmc_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wdata_lo   (bus_wdata[NUM_CH-1:0]),
    .pwm_out    (pwm_out),
    .en_bits    (en_bits),
    .cnt_all    (cnt_all),
    .per_sh_all (per_sh_all),
    .thr_sh_all (thr_sh_all)
);

// File: tb/sim_pwmc_top.sv
`timescale 1ns/1ps
module sim_pwmc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  pwm_out;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pwmc_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [8:0] wa(int ch, int ofs);
        return 9'(16 + ch * 64 + ofs);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_en(int ch, bit on);
        logic [31:0] v;
        rd(9'h000, v);
        v[ch] = on;
        wr(9'h000, v);
    endtask

    task automatic cfg(int ch, int dv, int per, int thr);
        wr(wa(ch, 0), 32'(dv));
        wr(wa(ch, 44), 32'(per));
        wr(wa(ch, 48), 32'(thr));
    endtask

    task automatic start(int ch, int dv, int per, int thr);
        set_en(ch, 1'b0);
        cfg(ch, dv, per, thr);
        set_en(ch, 1'b1);
    endtask

    // called on the sample where the output has just risen; ends on the next rise sample
    task automatic pulse_from_rise(int ch, output int hi, output int tot);
        int g;
        hi = 1; tot = 1; g = 0;
        while (g < 40000) begin
            @(negedge clk); g++;
            if (!pwm_out[ch]) break;
            hi++; tot++;
        end
        tot++;
        while (g < 40000) begin
            @(negedge clk); g++;
            if (pwm_out[ch]) break;
            tot++;
        end
        if (g >= 40000) begin hi = 0; tot = 0; end
    endtask

    task automatic wait_rise(int ch, output bit ok);
        logic prev;
        int g;
        ok = 1'b0; g = 0;
        @(negedge clk);
        prev = pwm_out[ch];
        while (g < 40000) begin
            @(negedge clk); g++;
            if (!prev && pwm_out[ch]) begin ok = 1'b1; break; end
            prev = pwm_out[ch];
        end
    endtask

    task automatic measure(int ch, output int hi, output int tot);
        bit ok;
        wait_rise(ch, ok);
        if (ok) pulse_from_rise(ch, hi, tot);
        else begin hi = 0; tot = 0; end
    endtask

    task automatic level_run(int ch, logic lvl, int n, output int bad);
        bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch] !== lvl) bad++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        #1;
        chk("R1 outputs after reset", 32'(pwm_out), 32'h0);
        rd(9'h000, v); chk("R1 run word after reset", v, 32'h0);
        rd(wa(2, 44), v); chk("R1 period ch2 after reset", v, 32'h0);
        rd(wa(4, 0), v); chk("R1 control ch4 after reset", v, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        for (int c = 0; c < 5; c++) begin
            wr(wa(c, 44), 32'(100 + c));
            wr(wa(c, 48), 32'(200 + c));
        end
        for (int c = 0; c < 5; c++) begin
            rd(wa(c, 44), v); chk($sformatf("R3 period ch%0d", c), v, 32'(100 + c));
            rd(wa(c, 48), v); chk($sformatf("R3 threshold ch%0d", c), v, 32'(200 + c));
        end
        wr(wa(4, 44), 32'h0000FFFF);
        rd(wa(4, 44), v); chk("R10 period width", v, 32'h1FFF);
        wr(wa(3, 48), 32'hFFFFFFFF);
        rd(wa(3, 48), v); chk("R10 threshold width", v, 32'h1FFF);
        wr(wa(1, 0), 32'hABCD800D);
        rd(wa(1, 0), v); chk("R9 control readback", v, 32'h800D);
        wr(wa(1, 4), 32'h11112222);
        wr(wa(1, 8), 32'h33334444);
        wr(wa(1, 12), 32'h55556666);
        wr(wa(1, 40), 32'h7777F888);
        rd(wa(1, 4), v);  chk("R9 spare +04", v, 32'h2222);
        rd(wa(1, 8), v);  chk("R9 spare +08", v, 32'h4444);
        rd(wa(1, 12), v); chk("R9 spare +0C", v, 32'h6666);
        rd(wa(1, 40), v); chk("R9 spare +28", v, 32'hF888);
        rd(wa(0, 0), v);  chk("R3 control ch0 untouched", v, 32'h0);
        rd(9'h000, v);    chk("R3 run word untouched", v, 32'h0);
    endtask

    task automatic t_basic;
        int hi, tot;
        start(0, 0, 10, 4);
        measure(0, hi, tot);
        chk("R5 high 10/4", 32'(hi), 32'd4);
        chk("R5 period 10/4", 32'(tot), 32'd10);
        start(0, 0, 7, 6);
        measure(0, hi, tot);
        chk("R5 high 7/6", 32'(hi), 32'd6);
        chk("R5 period 7/6", 32'(tot), 32'd7);
        start(0, 0, 25, 1);
        measure(0, hi, tot);
        chk("R5 high 25/1", 32'(hi), 32'd1);
        chk("R5 period 25/1", 32'(tot), 32'd25);
    endtask

    task automatic t_presc;
        int hi, tot;
        start(1, 2, 10, 3);
        measure(1, hi, tot);
        chk("R4 high div4", 32'(hi), 32'd12);
        chk("R4 period div4", 32'(tot), 32'd40);
        wr(wa(1, 4), 32'h0000FFFF);
        wr(wa(1, 40), 32'h00000000);
        measure(1, hi, tot);
        chk("R9 spare has no effect high", 32'(hi), 32'd12);
        chk("R9 spare has no effect period", 32'(tot), 32'd40);
        start(1, 7, 3, 1);
        measure(1, hi, tot);
        chk("R4 high div128", 32'(hi), 32'd128);
        chk("R4 period div128", 32'(tot), 32'd384);
        set_en(1, 1'b0);
    endtask

    task automatic t_extreme;
        int bad;
        start(2, 0, 10, 0);
        level_run(2, 1'b0, 60, bad);
        chk("R6 threshold 0 stays low", 32'(bad), 32'd0);
        start(2, 0, 10, 10);
        @(negedge clk);
        level_run(2, 1'b1, 60, bad);
        chk("R6 threshold = period stays high", 32'(bad), 32'd0);
        start(2, 0, 10, 8191);
        @(negedge clk);
        level_run(2, 1'b1, 60, bad);
        chk("R6 threshold max stays high", 32'(bad), 32'd0);
        set_en(2, 1'b0);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        int hi, tot;
        start(0, 0, 10, 4);
        set_en(3, 1'b1);
        rd(9'h000, v); chk("R2 run word after RMW", v, 32'h09);
        measure(0, hi, tot);
        chk("R2 ch0 high undisturbed", 32'(hi), 32'd4);
        chk("R2 ch0 period undisturbed", 32'(tot), 32'd10);
        set_en(3, 1'b0);
        rd(9'h000, v); chk("R2 run word after clear", v, 32'h01);
        wr(9'h000, 32'hFFFFFFE1);
        rd(9'h000, v); chk("R2 upper bits read zero", v, 32'h01);
    endtask

    task automatic t_fresh;
        int bad;
        logic s0, s1, s2, s3, s4;
        cfg(3, 0, 8, 3);
        level_run(3, 1'b0, 50, bad);
        chk("R7 disabled output low", 32'(bad), 32'd0);
        set_en(3, 1'b1);
        s0 = pwm_out[3];
        @(negedge clk); s1 = pwm_out[3];
        @(negedge clk); s2 = pwm_out[3];
        @(negedge clk); s3 = pwm_out[3];
        @(negedge clk); s4 = pwm_out[3];
        chk("R7 first cycle after write low", 32'(s0), 32'd0);
        chk("R7 start pattern", {28'h0, s1, s2, s3, s4}, 32'b1110);
        repeat (4) @(negedge clk);
        s0 = pwm_out[3];
        @(negedge clk); s1 = pwm_out[3];
        chk("R7 second period starts at 8", {30'h0, s0, s1}, 32'b01);
        set_en(3, 1'b0);
        @(negedge clk);
        level_run(3, 1'b0, 40, bad);
        chk("R7 low after disable", 32'(bad), 32'd0);
    endtask

    task automatic t_boundary;
        int hi, tot;
        bit ok;
        start(4, 0, 20, 5);
        wait_rise(4, ok);
        chk("R8 found rise", 32'(ok), 32'd1);
        fork
            begin
                wr(wa(4, 48), 32'd12);
                wr(wa(4, 44), 32'd30);
            end
            pulse_from_rise(4, hi, tot);
        join
        chk("R8 current pulse keeps old threshold", 32'(hi), 32'd5);
        chk("R8 current period keeps old length", 32'(tot), 32'd20);
        pulse_from_rise(4, hi, tot);
        chk("R8 next pulse uses new threshold", 32'(hi), 32'd12);
        chk("R8 next period uses new length", 32'(tot), 32'd30);
        set_en(4, 1'b0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        int hi, tot;
        start(0, 0, 7, 6);
        wr(wa(0, 52), 32'hFFFFFFFF);
        wr(wa(0, 20), 32'hFFFFFFFF);
        wr(9'h004, 32'hFFFFFFFF);
        wr(9'h150, 32'hFFFFFFFF);
        wr(9'h03E, 32'hFFFFFFFF);
        wr(9'h001, 32'hFFFFFFFF);
        rd(wa(0, 52), v); chk("R11 hole +34 reads zero", v, 32'h0);
        rd(wa(0, 20), v); chk("R11 hole +14 reads zero", v, 32'h0);
        rd(9'h004, v);    chk("R11 global hole reads zero", v, 32'h0);
        rd(9'h150, v);    chk("R11 past last window reads zero", v, 32'h0);
        rd(9'h03E, v);    chk("R11 misaligned reads zero", v, 32'h0);
        rd(wa(0, 44), v); chk("R11 ch0 period intact", v, 32'd7);
        rd(9'h000, v);    chk("R11 run word intact", v, 32'h01);
        measure(0, hi, tot);
        chk("R11 ch0 high intact", 32'(hi), 32'd6);
        chk("R11 ch0 period intact", 32'(tot), 32'd7);
    endtask

    task automatic t_long;
        int hi, tot;
        start(4, 0, 8191, 4000);
        measure(4, hi, tot);
        chk("R10 high at full period", 32'(hi), 32'd4000);
        chk("R10 full 8191 period", 32'(tot), 32'd8191);
        set_en(4, 1'b0);
    endtask

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_map();
                t_basic();
                t_presc();
                t_extreme();
                t_enable();
                t_fresh();
                t_boundary();
                t_unmapped();
                t_long();
            end
            begin
                repeat (150000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog all requirements actual=expired expected=finished");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule